// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Scanner

This block holds the controller-wide state of a four-channel DMA controller: the command byte, the per-channel mode bytes, the mask bits and an 8-bit status register. The status register keeps one request flag and one terminal-count flag for each channel. A host writes and reads the block through an 8-bit register port. Only offsets 8 to 15 belong to this block. Accesses with address bit 3 clear go to the address/count logic elsewhere and are ignored here.

Each cycle the block looks for channels that have a pending request and a clear mask bit. It grants the lowest-numbered of them on a one-hot grant vector. The transfer engine consumes that grant and returns terminal-count pulses. The engine also reads the mode bytes and the command byte, and it uses a one-cycle pulse from this block to clear its low/high byte flip-flop.

Top module: `dma_ctl_scan`

## Requirements
- R1: A write to offset 8 loads the command byte when the data is 0x00 or has only bit 2 set. Any other value leaves the command byte unchanged.
- R2: A write to offset 9 picks a channel from data bits 1..0. It sets that channel's request flag (status bit 4+ch) when data bit 2 is 1 and clears it when data bit 2 is 0. In both cases it clears the channel's terminal-count flag (status bit ch).
- R3: A write to offset 10 sets the mask bit of the channel in data bits 1..0 when data bit 2 is 1 and clears it when data bit 2 is 0.
- R4: A write to offset 11 stores the whole data byte as the mode byte of the channel in data bits 1..0. Mode byte ch appears on `mode_out[8*ch+7:8*ch]`.
- R5: A write to offset 12 raises `ff_clear` for exactly one cycle. A write to offset 13 also raises that pulse, sets every mask bit, and clears the status and command bytes.
- R6: A write to offset 14 clears all mask bits. A write to offset 15 loads the mask bits from data bits 3..0.
- R7: A read of offset 8 returns the status byte on `reg_rdata` one cycle later and then clears the terminal-count flags. A terminal-count pulse in the same cycle as the read is kept. A read of offset 15 returns the mask in bits 3..0 with bits 7..4 zero. Reads of other offsets return 0.
- R8: A rising edge of `dreq[ch]` sets the channel's request flag, and a falling edge clears it. A steady level changes nothing, so a request held high through a master reset stays cleared.
- R9: A pulse on `tc[ch]` sets terminal-count flag ch unless the same cycle carries a master-reset write.
- R10: `grant` is registered and at most one-hot. One cycle after the status and mask state changes, it marks the lowest-numbered channel whose request flag is set and whose mask bit is clear. It is zero when no channel qualifies.
- R11: After reset `grant`, `cmd_out`, `mode_out`, `ff_clear` and status are zero and all mask bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset; this block decodes 8..15 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| dreq | input | 4 | Per-channel hardware request levels |
| tc | input | 4 | Per-channel terminal-count pulses |
| grant | output | 4 | One-hot service grant |
| mode_out | output | 32 | Mode bytes, channel 0 in the low byte |
| cmd_out | output | 8 | Accepted command byte |
| ff_clear | output | 1 | One-cycle byte flip-flop clear pulse |

## Verification
Two situations are hard to reach from the ports.

The first is a request line that stays high across a master reset. Because the request flag is set only on an edge, the flag must stay clear afterwards, and the grant must stay low even after the masks are opened. The bench raises `dreq[0]` and holds it, issues the reset write, clears all masks, and then reads back status and grant.

The second is a terminal-count pulse that lands in the same cycle as a status read. The bench drives the pulse and the read strobe on the same edge. It checks that the returned byte lacks the new flag and that the next read shows it.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int CH_W   = 2;
  localparam int SEL_BIT = 2;
  localparam int REQ_OFS = 4;
  localparam logic [DATA_W-1:0] CMD_BAD_BITS = 8'hFB;

  typedef enum logic [3:0] {
    OFF_CMD_STAT = 4'h8,
    OFF_SREQ     = 4'h9,
    OFF_SMASK    = 4'hA,
    OFF_MODE     = 4'hB,
    OFF_CLRFF    = 4'hC,
    OFF_MRESET   = 4'hD,
    OFF_CLRMASK  = 4'hE,
    OFF_WRMASK   = 4'hF
  } ctl_off_e;
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [3:0]            addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     cmd_q,
  output logic [NCH-1:0]        mask_q,
  output logic [NCH*DATA_W-1:0] mode_q,
  output logic                  ff_clr_q
);
  logic wr_cmd, wr_smask, wr_mode, wr_clrff, wr_mrst, wr_clrmask, wr_wrmask;
  logic cmd_ok;

  assign wr_cmd     = wr_en && (addr == OFF_CMD_STAT);
  assign wr_smask   = wr_en && (addr == OFF_SMASK);
  assign wr_mode    = wr_en && (addr == OFF_MODE);
  assign wr_clrff   = wr_en && (addr == OFF_CLRFF);
  assign wr_mrst    = wr_en && (addr == OFF_MRESET);
  assign wr_clrmask = wr_en && (addr == OFF_CLRMASK);
  assign wr_wrmask  = wr_en && (addr == OFF_WRMASK);
  assign cmd_ok     = (wdata & CMD_BAD_BITS) == '0;

  always_ff @(posedge clk) begin
    if (rst || wr_mrst) begin
      cmd_q <= '0;
    end else if (wr_cmd && cmd_ok) begin
      cmd_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_clr_q <= 1'b0;
    end else begin
      ff_clr_q <= wr_clrff || wr_mrst;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst || wr_mrst) begin
        mask_q[i] <= 1'b1;
      end else if (wr_clrmask) begin
        mask_q[i] <= 1'b0;
      end else if (wr_wrmask) begin
        mask_q[i] <= wdata[i];
      end else if (wr_smask && (wdata[CH_W-1:0] == CH_W'(i))) begin
        mask_q[i] <= wdata[SEL_BIT];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i*DATA_W +: DATA_W] <= '0;
      end else if (wr_mode && (wdata[CH_W-1:0] == CH_W'(i))) begin
        mode_q[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              stat_rd,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    dreq,
  input  logic [NCH-1:0]    tc,
  output logic [NCH-1:0]    req_q,
  output logic [NCH-1:0]    tc_q
);
  logic [NCH-1:0] dreq_q;
  logic wr_sreq, wr_mrst;

  assign wr_sreq = wr_en && (addr == OFF_SREQ);
  assign wr_mrst = wr_en && (addr == OFF_MRESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_q <= '0;
    end else begin
      dreq_q <= dreq;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit, rise, fall;
    assign hit  = wr_sreq && (wdata[CH_W-1:0] == CH_W'(i));
    assign rise = dreq[i] && !dreq_q[i];
    assign fall = !dreq[i] && dreq_q[i];

    always_ff @(posedge clk) begin
      if (rst || wr_mrst) begin
        req_q[i] <= 1'b0;
      end else if (hit) begin
        req_q[i] <= wdata[SEL_BIT];
      end else if (rise) begin
        req_q[i] <= 1'b1;
      end else if (fall) begin
        req_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || wr_mrst) begin
        tc_q[i] <= 1'b0;
      end else if (tc[i]) begin
        tc_q[i] <= 1'b1;
      end else if (hit || stat_rd) begin
        tc_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_ctl_arb.sv
module dma_ctl_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] grant_q
);
  logic [NCH-1:0] ready, pick;
  logic           found;

  assign ready = req & ~mask;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ready[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
    end else begin
      grant_q <= pick;
    end
  end
endmodule

// File: rtl/dma_ctl_scan.sv
module dma_ctl_scan
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [3:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]        dreq,
  input  logic [NCH-1:0]        tc,
  output logic [NCH-1:0]        grant,
  output logic [NCH*DATA_W-1:0] mode_out,
  output logic [DATA_W-1:0]     cmd_out,
  output logic                  ff_clear
);
  logic [NCH-1:0]    mask_q, req_q, tc_q;
  logic [DATA_W-1:0] status_byte, mask_byte;
  logic              stat_rd, mask_rd;

  assign stat_rd     = reg_rd && (reg_addr == OFF_CMD_STAT);
  assign mask_rd     = reg_rd && (reg_addr == OFF_WRMASK);
  assign status_byte = (DATA_W'(req_q) << REQ_OFS) | DATA_W'(tc_q);
  assign mask_byte   = DATA_W'(mask_q);

  dma_ctl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cmd_q(cmd_out), .mask_q(mask_q), .mode_q(mode_out), .ff_clr_q(ff_clear)
  );

  dma_ctl_status #(.NCH(NCH)) u_status (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .stat_rd(stat_rd), .addr(reg_addr),
    .wdata(reg_wdata), .dreq(dreq), .tc(tc), .req_q(req_q), .tc_q(tc_q)
  );

  dma_ctl_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst(rst), .req(req_q), .mask(mask_q), .grant_q(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (stat_rd) begin
      reg_rdata <= status_byte;
    end else if (mask_rd) begin
      reg_rdata <= mask_byte;
    end else if (reg_rd) begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/dma_ctl_scan_chk.sv
module dma_ctl_scan_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [3:0]     reg_addr,
  input logic [7:0]     reg_wdata,
  input logic [NCH-1:0] dreq,
  input logic [NCH-1:0] tc,
  input logic [NCH-1:0] grant,
  input logic [7:0]     cmd_out,
  input logic           ff_clear,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] req_q,
  input logic [NCH-1:0] tc_q
);
  // R1
  cmd_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'h8 && (reg_wdata & 8'hFB) != 8'h00) |=> $stable(cmd_out));

  // R5
  ff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == 4'hC || reg_addr == 4'hD)) |=> ff_clear);

  // R5
  mreset_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'hD) |=> (&mask_q && cmd_out == 8'h00 && req_q == '0 && tc_q == '0));

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 4'h8 && !reg_wr && tc == '0) |=> (tc_q == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R10
    grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> $past(req_q[i] && !mask_q[i]));

    // R8
    dreq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (!reg_wr && $rose(dreq[i])) |=> req_q[i]);

    // R9
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
      (tc[i] && !(reg_wr && reg_addr == 4'hD)) |=> tc_q[i]);
  end
endmodule

bind dma_ctl_scan dma_ctl_scan_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dreq(dreq), .tc(tc), .grant(grant), .cmd_out(cmd_out),
  .ff_clear(ff_clear), .mask_q(mask_q), .req_q(req_q), .tc_q(tc_q)
);

// File: tb/dma_ctl_scan_bench.sv
module dma_ctl_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  dreq = '0, tc = '0;
  logic [3:0]  grant;
  logic [31:0] mode_out;
  logic [7:0]  cmd_out;
  logic        ff_clear;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_scan #(.NCH(NCH)) u_dma_ctl_scan (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .tc(tc),
    .grant(grant), .mode_out(mode_out), .cmd_out(cmd_out), .ff_clear(ff_clear)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R11 grant", 32'(grant), 0);
    chk("R11 cmd", 32'(cmd_out), 0);
    chk("R11 mode", mode_out, 0);
    chk("R11 ff_clear", 32'(ff_clear), 0);
    rd(4'hF, v); chk("R11 mask", 32'(v), 32'h0F);
    rd(4'h8, v); chk("R11 status", 32'(v), 0);
  endtask

  task automatic t_command;
    wr(4'h8, 8'h04); chk("R1 accept 0x04", 32'(cmd_out), 32'h04);
    wr(4'h8, 8'h05); chk("R1 reject 0x05", 32'(cmd_out), 32'h04);
    wr(4'h8, 8'h14); chk("R1 reject 0x14", 32'(cmd_out), 32'h04);
    wr(4'h8, 8'h00); chk("R1 accept 0x00", 32'(cmd_out), 0);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h46);
    chk("R4 mode ch2", 32'(mode_out[23:16]), 32'h46);
    chk("R4 other modes", 32'({mode_out[31:24], mode_out[15:0]}), 0);
    wr(4'hB, 8'hA9);
    chk("R4 mode ch1", 32'(mode_out[15:8]), 32'hA9);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(4'hE, 8'h00); rd(4'hF, v); chk("R6 clear all", 32'(v), 0);
    wr(4'hA, 8'h07); rd(4'hF, v); chk("R3 set ch3", 32'(v), 32'h08);
    wr(4'hF, 8'h05); rd(4'hF, v); chk("R6 load", 32'(v), 32'h05);
    wr(4'hA, 8'h00); rd(4'hF, v); chk("R3 clear ch0", 32'(v), 32'h04);
    rd(4'hA, v); chk("R7 other offset reads 0", 32'(v), 0);
    wr(4'hE, 8'h00);
  endtask

  task automatic t_soft_req;
    logic [7:0] v;
    wr(4'h9, 8'h06);
    @(negedge clk); chk("R2 R10 sw req grant", 32'(grant), 32'h4);
    rd(4'h8, v); chk("R2 status req", 32'(v), 32'h40);
    wr(4'h9, 8'h02);
    @(negedge clk); chk("R2 R10 sw clear grant", 32'(grant), 0);
    rd(4'h8, v); chk("R2 status cleared", 32'(v), 0);
  endtask

  task automatic t_hw_req;
    logic [7:0] v;
    @(negedge clk); dreq = 4'b0010;
    @(negedge clk); @(negedge clk);
    chk("R8 R10 hw ch1 grant", 32'(grant), 32'h2);
    dreq = 4'b1010;
    @(negedge clk); @(negedge clk);
    chk("R10 lowest wins", 32'(grant), 32'h2);
    wr(4'hA, 8'h05);
    @(negedge clk); chk("R10 masked skip", 32'(grant), 32'h8);
    rd(4'h8, v); chk("R8 status two req", 32'(v), 32'hA0);
    dreq = 4'b0000;
    @(negedge clk); @(negedge clk);
    chk("R8 R10 drop grant", 32'(grant), 0);
    rd(4'h8, v); chk("R8 drop clears", 32'(v), 0);
    wr(4'hA, 8'h01);
  endtask

  task automatic t_tc;
    logic [7:0] v;
    @(negedge clk); tc = 4'b0100;
    @(negedge clk); tc = 4'b0000;
    rd(4'h8, v); chk("R9 tc set", 32'(v), 32'h04);
    rd(4'h8, v); chk("R7 clear on read", 32'(v), 0);
    @(negedge clk); tc = 4'b0100;
    @(negedge clk); tc = 4'b0000;
    wr(4'h9, 8'h02);
    rd(4'h8, v); chk("R2 sw write clears tc", 32'(v), 0);
    // R7 tc pulse coinciding with status read survives
    @(negedge clk); tc = 4'b0010; reg_rd = 1'b1; reg_addr = 4'h8;
    @(negedge clk); tc = 4'b0000; reg_rd = 1'b0;
    chk("R7 coincident read old", 32'(reg_rdata), 0);
    rd(4'h8, v); chk("R7 coincident tc kept", 32'(v), 32'h02);
  endtask

  task automatic t_ff_and_reset;
    logic [7:0] v;
    wr(4'hC, 8'h00); chk("R5 ff pulse", 32'(ff_clear), 1);
    @(negedge clk); chk("R5 ff one cycle", 32'(ff_clear), 0);
    wr(4'h8, 8'h04);
    wr(4'h9, 8'h04);
    @(negedge clk); dreq = 4'b0001;
    @(negedge clk);
    wr(4'hD, 8'h00);
    chk("R5 mreset pulse", 32'(ff_clear), 1);
    chk("R5 mreset cmd", 32'(cmd_out), 0);
    rd(4'hF, v); chk("R5 mreset mask", 32'(v), 32'h0F);
    rd(4'h8, v); chk("R5 mreset status", 32'(v), 0);
    wr(4'hE, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R8 held level no grant", 32'(grant), 0);
    rd(4'h8, v); chk("R8 held level no req", 32'(v), 0);
    dreq = 4'b0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_command();
    t_mode();
    t_mask();
    t_soft_req();
    t_hw_req();
    t_tc();
    t_ff_and_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule